// File: doc/BRIEF.md
# EEPROM Page Write Collector and Commit Controller

This block sits behind a serial-bus protocol engine inside a byte-alterable non-volatile memory model. The memory holds 1024 bytes in 64 pages of 16 bytes. The upper six address bits select the page and the lower four select the byte inside it.

When the protocol engine signals the start of a write transfer, the block records the start address. Each data byte the engine accepts goes into a 16-entry page latch, and a valid bit is set for the lane that byte landed in. The in-page pointer advances after every accepted byte and wraps within the page, so any surplus bytes land on the first bytes of that same page.

When STOP arrives, the block checks two things: that STOP fell in the bit slot right after a data byte's acknowledge, and that at least one lane is valid. If both hold, it raises busy for a fixed, parameterised number of clocks. When busy drops, it copies the valid lanes into the array and moves the shared address counter past the last byte written. If either check fails, the pending write is dropped. A combinational read port exposes the array contents.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, busy is 0, addr_cnt is 0 and every array byte reads 0.
- R2: A single accepted byte at address A, followed by a qualifying STOP, writes that byte to A. After the cycle, addr_cnt equals the page bits of A joined with (A[3:0]+1) mod 16.
- R3: N accepted bytes (1 to 16) from start address A land on consecutive in-page offsets starting at A[3:0], and addr_cnt ends at the page of A with offset (A[3:0]+N) mod 16.
- R4: Bytes past offset 15 wrap to offset 0 of the same page. A later byte to the same offset replaces the earlier one, and no other page changes.
- R5: Array bytes in the page that were not written during the transfer keep their previous values.
- R6: A STOP with slot_after_ack=0 discards the pending write: busy stays 0, and the array and addr_cnt stay unchanged.
- R7: A qualifying STOP sampled at clock edge E raises busy after E, and busy stays high for exactly CYCLE_COUNT clocks. The array and addr_cnt update at the edge where busy falls, and addr_cnt does not change at any other time.
- R8: A data byte strobed with wc_inhibit=1 is refused: it sets no valid lane and does not advance the pointer. If every byte of a transfer is refused, a qualifying STOP starts no cycle.
- R9: While busy is 1, the start, byte and STOP strobes are ignored. After the cycle ends, no second cycle follows and the array shows no trace of those strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | One-clock strobe: a write transfer begins at wr_addr |
| wr_addr | input | 10 | Start address of the transfer |
| byte_stb | input | 1 | One-clock strobe: a data byte was received |
| byte_val | input | 8 | Value of the received data byte |
| wc_inhibit | input | 1 | Write control high; the byte in this strobe is refused |
| slot_after_ack | input | 1 | The current bit slot is the one right after a data-byte acknowledge |
| stop_stb | input | 1 | One-clock strobe: STOP was detected |
| rd_addr | input | 10 | Array read address |
| busy | output | 1 | A write cycle is in progress |
| addr_cnt | output | 10 | Shared address counter |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The assertions assume that each strobe lasts one clock. They also assume slot_after_ack is read only in the cycle where stop_stb is high, and that wr_start, byte_stb and stop_stb are never active in the same cycle. The bench tasks drive exactly one strobe per clock and clear every strobe in the following clock, so these assumptions always hold. The bench does deliberately issue strobes while busy is high, because R9 requires them to be ignored.

// File: rtl/epc_pkg.sv
`timescale 1ns/1ps
package epc_pkg;
   typedef enum logic {
      EPC_IDLE = 1'b0,
      EPC_FILL = 1'b1
   } epc_state_t;
endpackage

// File: rtl/epc_page_latch.sv
`timescale 1ns/1ps
module epc_page_latch
   import epc_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int OFF_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              busy,
   input  logic                              wr_start,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic                              byte_stb,
   input  logic [DATA_W-1:0]                 byte_val,
   input  logic                              wc_inhibit,
   input  logic                              slot_after_ack,
   input  logic                              stop_stb,
   output logic                              start_req,
   output logic [ADDR_W-OFF_W-1:0]           page,
   output logic [OFF_W-1:0]                  ptr,
   output logic [(1<<OFF_W)-1:0]             mask,
   output logic [(1<<OFF_W)-1:0][DATA_W-1:0] lane_data
);
   localparam int LANES = 1 << OFF_W;

   epc_state_t state;
   logic       live;
   logic       accept;
   logic       discard;
   logic       clear;

   assign live      = !busy && (state == EPC_FILL) && !wr_start;
   assign accept    = live && !stop_stb && byte_stb && !wc_inhibit;
   assign start_req = live && stop_stb && slot_after_ack && (|mask);
   assign discard   = live && stop_stb && !start_req;
   assign clear     = (!busy && wr_start) || discard;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= EPC_IDLE;
         page  <= '0;
         ptr   <= '0;
      end else if (!busy) begin
         if (wr_start) begin
            state <= EPC_FILL;
            page  <= wr_addr[ADDR_W-1:OFF_W];
            ptr   <= wr_addr[OFF_W-1:0];
         end else if (state == EPC_FILL && stop_stb) begin
            state <= EPC_IDLE;
         end else if (accept) begin
            ptr <= ptr + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask[i]      <= 1'b0;
            lane_data[i] <= '0;
         end else if (clear) begin
            mask[i] <= 1'b0;
         end else if (accept && ptr == OFF_W'(i)) begin
            mask[i]      <= 1'b1;
            lane_data[i] <= byte_val;
         end
      end
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ptr == {OFF_W{1'b1}}) |=> (ptr == '0)); // R4
   AST_REFUSED_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && wc_inhibit && !wr_start && !stop_stb) |=> $stable(mask)); // R8
   AST_NO_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> (mask != '0)); // R8
   AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(mask) && $stable(ptr) && $stable(page))); // R9
endmodule

// File: rtl/epc_write_timer.sv
`timescale 1ns/1ps
module epc_write_timer #(
   parameter int CYCLE_COUNT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   output logic busy,
   output logic done
);
   localparam int CNT_W = $clog2(CYCLE_COUNT + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end else if (start_req) begin
         busy <= 1'b1;
         cnt  <= CNT_W'(CYCLE_COUNT - 1);
      end
   end

   assign done = busy && (cnt == '0);

   AST_BUSY_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_req)); // R7
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CYCLE_COUNT - 1)); // R7
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R7
endmodule

// File: rtl/epc_array.sv
`timescale 1ns/1ps
module epc_array #(
   parameter int ADDR_W      = 10,
   parameter int OFF_W       = 4,
   parameter int DATA_W      = 8,
   parameter bit RESET_ARRAY = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              commit,
   input  logic [ADDR_W-OFF_W-1:0]           page,
   input  logic [(1<<OFF_W)-1:0]             mask,
   input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] lane_data,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = 1 << OFF_W;

   logic [DATA_W-1:0] mem [DEPTH];

   if (RESET_ARRAY) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
         end else if (commit) begin
            for (int i = 0; i < LANES; i++)
               if (mask[i]) mem[{page, OFF_W'(i)}] <= lane_data[i];
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (commit) begin
            for (int i = 0; i < LANES; i++)
               if (mask[i]) mem[{page, OFF_W'(i)}] <= lane_data[i];
         end
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_commit.sv
`timescale 1ns/1ps
module eeprom_page_commit #(
   parameter int ADDR_W      = 10,
   parameter int OFF_W       = 4,
   parameter int DATA_W      = 8,
   parameter int CYCLE_COUNT = 1000000,
   parameter bit RESET_ARRAY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_val,
   input  logic              wc_inhibit,
   input  logic              slot_after_ack,
   input  logic              stop_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic [ADDR_W-1:0] addr_cnt,
   output logic [DATA_W-1:0] rd_data
);
   localparam int LANES  = 1 << OFF_W;
   localparam int PAGE_W = ADDR_W - OFF_W;

   if (OFF_W < 1 || OFF_W >= ADDR_W) begin : g_bad_off
      $error("OFF_W must lie between 1 and ADDR_W-1");
   end
   if (CYCLE_COUNT < 1) begin : g_bad_cnt
      $error("CYCLE_COUNT must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic                          start_req;
   logic                          done;
   logic [PAGE_W-1:0]             page;
   logic [OFF_W-1:0]              ptr;
   logic [LANES-1:0]              mask;
   logic [LANES-1:0][DATA_W-1:0]  lane_data;

   epc_page_latch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_latch (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_stb(byte_stb), .byte_val(byte_val), .wc_inhibit(wc_inhibit),
      .slot_after_ack(slot_after_ack), .stop_stb(stop_stb),
      .start_req(start_req), .page(page), .ptr(ptr), .mask(mask),
      .lane_data(lane_data)
   );

   epc_write_timer #(.CYCLE_COUNT(CYCLE_COUNT)) i_timer (
      .clk(clk), .rst_n(rst_n), .start_req(start_req),
      .busy(busy), .done(done)
   );

   epc_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
               .RESET_ARRAY(RESET_ARRAY)) i_array (
      .clk(clk), .rst_n(rst_n), .commit(done), .page(page), .mask(mask),
      .lane_data(lane_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_cnt <= '0;
      else if (done) addr_cnt <= {page, ptr};
   end

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(addr_cnt)); // R7
   AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_stb && !slot_after_ack && !busy) |=> !busy); // R6
endmodule

// File: tb/test_eeprom_page_commit.sv
`timescale 1ns/1ps
module test_eeprom_page_commit;
   localparam int CYC = 20;

   typedef struct {
      int          addr;
      logic [7:0]  d;
      string       tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_start = 1'b0;
   logic [9:0] wr_addr = '0;
   logic       byte_stb = 1'b0;
   logic [7:0] byte_val = '0;
   logic       wc_inhibit = 1'b0;
   logic       slot_after_ack = 1'b0;
   logic       stop_stb = 1'b0;
   logic [9:0] rd_addr = '0;
   logic       busy;
   logic [9:0] addr_cnt;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit mon_idle = 1'b1;
   event go;
   item_t q[$];
   logic [7:0] exp_mem [1024];
   int exp_cnt = 0;
   int m_pg, m_ptr;
   logic [15:0] m_mask;
   logic [7:0]  m_lat [16];

   always #2 clk = ~clk;

   eeprom_page_commit #(.CYCLE_COUNT(CYC)) i_eeprom_page_commit (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_stb(byte_stb), .byte_val(byte_val), .wc_inhibit(wc_inhibit),
      .slot_after_ack(slot_after_ack), .stop_stb(stop_stb), .rd_addr(rd_addr),
      .busy(busy), .addr_cnt(addr_cnt), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(go);
         while (q.size() > 0) begin
            it = q.pop_front();
            rd_addr = it.addr[9:0];
            #1;
            chk(rd_data === it.d, it.tag, int'(rd_data), int'(it.d));
         end
         mon_idle = 1'b1;
      end
   end

   task automatic run_monitor();
      mon_idle = 1'b0;
      ->go;
      wait (mon_idle);
   endtask

   task automatic push_page(input int a, input string tag);
      int base;
      item_t it;
      base = (a / 16) * 16;
      for (int i = 0; i < 16; i++) begin
         it.addr = base + i;
         it.d = exp_mem[base + i];
         it.tag = tag;
         q.push_back(it);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic send_start(input int a);
      wr_start = 1'b1; wr_addr = a[9:0];
      tick();
      wr_start = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input bit inh);
      byte_stb = 1'b1; byte_val = v; wc_inhibit = inh;
      tick();
      byte_stb = 1'b0; wc_inhibit = 1'b0;
   endtask

   task automatic send_stop(input bit slot);
      stop_stb = 1'b1; slot_after_ack = slot;
      tick();
      stop_stb = 1'b0; slot_after_ack = 1'b0;
   endtask

   task automatic xfer(input int a, input int n, input int seed,
                       input logic [31:0] inh, input bit slot, output bit starts);
      logic [7:0] v;
      send_start(a);
      m_pg = a / 16; m_ptr = a % 16; m_mask = '0;
      for (int i = 0; i < n; i++) begin
         v = 8'((seed + i * 7) & 255);
         send_byte(v, inh[i]);
         if (!inh[i]) begin
            m_lat[m_ptr] = v;
            m_mask[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % 16;
         end
      end
      send_stop(slot);
      starts = slot && (m_mask != '0);
   endtask

   task automatic finish_cycle(input int spent, input string tag);
      int expc;
      chk(busy === 1'b1, {tag, " R7 busy after STOP"}, int'(busy), 1);
      chk(addr_cnt === 10'(exp_cnt), {tag, " R7 addr_cnt held"}, int'(addr_cnt), exp_cnt);
      repeat (CYC - 1 - spent) tick();
      chk(busy === 1'b1, {tag, " R7 busy last cycle"}, int'(busy), 1);
      tick();
      chk(busy === 1'b0, {tag, " R7 busy released"}, int'(busy), 0);
      expc = m_pg * 16 + m_ptr;
      chk(addr_cnt === 10'(expc), {tag, " addr_cnt after cycle"}, int'(addr_cnt), expc);
      exp_cnt = expc;
      for (int i = 0; i < 16; i++)
         if (m_mask[i]) exp_mem[m_pg * 16 + i] = m_lat[i];
   endtask

   task automatic no_cycle(input string tag);
      repeat (3) begin
         chk(busy === 1'b0, {tag, " no busy"}, int'(busy), 0);
         tick();
      end
      chk(addr_cnt === 10'(exp_cnt), {tag, " addr_cnt unchanged"}, int'(addr_cnt), exp_cnt);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : driver
      bit st;
      for (int k = 0; k < 1024; k++) exp_mem[k] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      chk(busy === 1'b0, "R1 busy", int'(busy), 0);
      chk(addr_cnt === 10'd0, "R1 addr_cnt", int'(addr_cnt), 0);
      push_page(10'h013, "R1 array zero");
      run_monitor();

      // R2 byte write
      xfer(10'h013, 1, 8'hA5, 32'h0, 1'b1, st);
      finish_cycle(0, "R2");
      push_page(10'h013, "R2 byte written");
      run_monitor();

      // R3 page write of five bytes
      xfer(10'h040, 5, 8'h11, 32'h0, 1'b1, st);
      finish_cycle(0, "R3");
      push_page(10'h040, "R3 page bytes");
      run_monitor();

      // R4 rollover: 20 bytes from offset 12
      xfer(10'h07C, 20, 8'h30, 32'h0, 1'b1, st);
      finish_cycle(0, "R4");
      push_page(10'h07C, "R4 wrap page");
      push_page(10'h080, "R4 next page untouched");
      run_monitor();

      // R5 partial rewrite keeps other bytes
      xfer(10'h045, 2, 8'hC0, 32'h0, 1'b1, st);
      finish_cycle(0, "R5");
      push_page(10'h040, "R5 old bytes kept");
      run_monitor();

      // R6 STOP outside the post-ACK slot
      xfer(10'h100, 3, 8'h55, 32'h0, 1'b0, st);
      no_cycle("R6");
      push_page(10'h100, "R6 array unchanged");
      run_monitor();

      // R8 all bytes refused
      xfer(10'h200, 2, 8'h66, 32'h3, 1'b1, st);
      no_cycle("R8 all refused");
      push_page(10'h200, "R8 array unchanged");
      run_monitor();

      // R8 mixed refused and accepted bytes
      xfer(10'h210, 4, 8'h70, 32'h5, 1'b1, st);
      finish_cycle(0, "R8 mixed");
      push_page(10'h210, "R8 accepted only");
      run_monitor();

      // R9 strobes during busy are ignored
      xfer(10'h300, 1, 8'h9C, 32'h0, 1'b1, st);
      wr_start = 1'b1; wr_addr = 10'h380;
      tick();
      wr_start = 1'b0;
      byte_stb = 1'b1; byte_val = 8'hEE;
      tick();
      byte_stb = 1'b0;
      stop_stb = 1'b1; slot_after_ack = 1'b1;
      tick();
      stop_stb = 1'b0; slot_after_ack = 1'b0;
      finish_cycle(3, "R9");
      no_cycle("R9 no second cycle");
      push_page(10'h300, "R9 real write");
      push_page(10'h380, "R9 ignored page");
      run_monitor();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule